// File: doc/BRIEF.md
# PHY Polling Unit with Host Access Arbitration

This block runs background polling of a set of attached PHYs over a shared management path. While polling is on, it issues one transaction at a time, visiting the PHYs in round-robin order, and waits for the path to acknowledge each transaction before it issues the next one. A host that needs the management path raises a request. The unit then clears its polling enable bit and waits until any transaction already in flight has completed. Once the two-bit polling state reads stopped, it grants the path to the host.

When the host releases the path, the unit does not restart polling at once. It waits for a fixed number of quiet cycles and then sets the enable bit again by itself. If the host asks again within that quiet window, the pending restart is cancelled and the path is granted on the next cycle, with no second stop handshake. If the in-flight transaction never completes, the stop handshake gives up after a bounded number of cycles. It then reports a failure to the host and turns polling back on.

Top module: `phy_poll_arbiter`

## Requirements
- R1: After reset `ctrl_en` is 1, `acc_grant` and `acc_fail` are 0, `poll_state` is 2'b11, and the first poll transaction targets PHY 0.
- R2: `poll_state` is 2'b11 while polling is enabled or a poll transaction is outstanding, and 2'b00 otherwise. No other code ever appears.
- R3: Poll transactions visit PHY indices 0, 1, ..., NUM_PHYS-1 and then wrap to 0. At most one transaction is outstanding. `poll_req` is asserted only while `ctrl_en` is 1 and no transaction is outstanding, and a transaction completes on `poll_ack`.
- R4: A host request made while polling is active clears `ctrl_en` on the next clock edge. `acc_grant` is raised only after `poll_state` has left 2'b11.
- R5: While `acc_grant` is 1 no poll is issued and `ctrl_en` stays 0, however long the host holds the path. Re-enabling is not attempted during an access.
- R6: After `acc_req` falls during a grant, `ctrl_en` returns to 1 exactly QUIET_CYCLES clock cycles later, and polling resumes.
- R7: A request raised during the quiet window is granted on the next clock edge while `ctrl_en` stays 0. The quiet window then restarts from zero when that access ends.
- R8: If `poll_state` is still 2'b11 TIMEOUT_CYCLES cycles after a request starts the stop handshake, `acc_fail` rises, `ctrl_en` returns to 1 and no grant is given. `acc_fail` stays high until `acc_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Host wants the management path (level) |
| acc_grant | output | 1 | Path belongs to the host |
| acc_fail | output | 1 | Stop handshake timed out; held until acc_req falls |
| ctrl_en | output | 1 | Polling enable bit |
| poll_state | output | 2 | 2'b11 polling active, 2'b00 stopped |
| poll_req | output | 1 | Issue a poll transaction this cycle |
| poll_phy | output | PHY_W | PHY index of the issued poll |
| poll_ack | input | 1 | Outstanding poll transaction has completed |

## Verification
Polling is exercised with a responder that acknowledges each transaction a few cycles after it is issued. This shows that the round-robin order wraps correctly and that only one transaction is outstanding at a time.

Host requests are tried in four patterns, each telling apart a different part of the arbitration:
- A request made while polling is active shows that the grant waits for the stop handshake.
- An access held far longer than the quiet window shows that no restart happens during an access.
- A second request made inside the quiet window shows that the restart is cancelled and the window starts again from zero.
- A request made while the responder withholds its acknowledgement shows the exact timeout cycle and the return to polling.

// File: rtl/phy_poll_arbiter.sv
module phy_poll_arbiter #(
  parameter int NUM_PHYS       = 4,
  parameter int QUIET_CYCLES   = 500000,
  parameter int TIMEOUT_CYCLES = 50000000,
  localparam int PHY_W = (NUM_PHYS > 1) ? $clog2(NUM_PHYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_req,
  output logic             acc_grant,
  output logic             acc_fail,
  output logic             ctrl_en,
  output logic [1:0]       poll_state,
  output logic             poll_req,
  output logic [PHY_W-1:0] poll_phy,
  input  logic             poll_ack
);
  localparam int LIM   = (QUIET_CYCLES > TIMEOUT_CYCLES) ? QUIET_CYCLES : TIMEOUT_CYCLES;
  localparam int CNT_W = $clog2(LIM + 1);

  typedef enum logic [2:0] {S_RUN, S_DRAIN, S_HOST, S_QUIET, S_FAIL} st_t;

  st_t              st;
  logic             en, busy;
  logic [PHY_W-1:0] phy;
  logic [CNT_W-1:0] cnt;

  wire active = en | busy;
  wire [PHY_W-1:0] phy_nxt = (phy == PHY_W'(NUM_PHYS - 1)) ? '0 : phy + 1'b1;

  assign poll_req   = en & ~busy;
  assign poll_phy   = phy;
  assign poll_state = {active, active};
  assign ctrl_en    = en;
  assign acc_grant  = (st == S_HOST);
  assign acc_fail   = (st == S_FAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_RUN;
      en   <= 1'b1;
      busy <= 1'b0;
      phy  <= '0;
      cnt  <= '0;
    end else begin
      if (busy && poll_ack) begin
        busy <= 1'b0;
        phy  <= phy_nxt;
      end else if (poll_req) begin
        busy <= 1'b1;
      end

      case (st)
        S_RUN: if (acc_req) begin
          en  <= 1'b0;
          cnt <= '0;
          st  <= S_DRAIN;
        end
        S_DRAIN: begin
          if (!active) st <= S_HOST;
          else if (cnt == CNT_W'(TIMEOUT_CYCLES - 1)) begin
            en <= 1'b1;
            st <= S_FAIL;
          end else cnt <= cnt + 1'b1;
        end
        S_HOST: if (!acc_req) begin
          cnt <= '0;
          st  <= S_QUIET;
        end
        S_QUIET: begin
          if (acc_req) st <= S_HOST;
          else if (cnt == CNT_W'(QUIET_CYCLES - 1)) begin
            en <= 1'b1;
            st <= S_RUN;
          end else cnt <= cnt + 1'b1;
        end
        S_FAIL: if (!acc_req) st <= S_RUN;
        default: st <= S_RUN;
      endcase
    end
  end
endmodule

// File: rtl/phy_poll_arbiter_chk.sv
module phy_poll_arbiter_chk #(
  parameter int PHY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_req,
  input logic             acc_grant,
  input logic             acc_fail,
  input logic             ctrl_en,
  input logic [1:0]       poll_state,
  input logic             poll_req,
  input logic [PHY_W-1:0] poll_phy,
  input logic             poll_ack
);
  assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_state == 2'b00) || (poll_state == 2'b11));

  assert_req_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |-> ctrl_en);

  assert_grant_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_grant) |-> ($past(poll_state) != 2'b11));

  assert_grant_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> (!poll_req && !ctrl_en && poll_state == 2'b00));

  assert_disable_on_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_en) |-> $past(acc_req));

  assert_no_reen_in_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_en) |-> !$past(acc_grant));

  assert_fail_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fail |-> (!acc_grant && ctrl_en));
endmodule

bind phy_poll_arbiter phy_poll_arbiter_chk #(.PHY_W(PHY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_grant(acc_grant),
  .acc_fail(acc_fail), .ctrl_en(ctrl_en), .poll_state(poll_state),
  .poll_req(poll_req), .poll_phy(poll_phy), .poll_ack(poll_ack)
);

// File: tb/phy_poll_arbiter_test.sv
`timescale 1ns/1ps
module phy_poll_arbiter_test;
  localparam int NP  = 4;
  localparam int QC  = 20;
  localparam int TC  = 30;
  localparam int LAT = 3;
  localparam int PW  = 2;

  logic clk = 0, rst_n = 0, acc_req = 0, poll_ack = 0;
  logic acc_grant, acc_fail, ctrl_en, poll_req;
  logic [1:0] poll_state;
  logic [PW-1:0] poll_phy;

  always #10 clk = ~clk;

  phy_poll_arbiter #(.NUM_PHYS(NP), .QUIET_CYCLES(QC), .TIMEOUT_CYCLES(TC)) uut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_grant(acc_grant),
    .acc_fail(acc_fail), .ctrl_en(ctrl_en), .poll_state(poll_state),
    .poll_req(poll_req), .poll_phy(poll_phy), .poll_ack(poll_ack));

  int total = 0, failed = 0;
  int resp_cnt = 0;
  bit ack_on = 1;
  int log_n = 0;
  int log_phy [0:15];

  always @(negedge clk) begin
    poll_ack = 0;
    if (rst_n) begin
      if (resp_cnt > 1) resp_cnt--;
      else if (resp_cnt == 1) begin
        if (ack_on) begin poll_ack = 1; resp_cnt = 0; end
      end else if (poll_req) begin
        resp_cnt = LAT;
        if (log_n < 16) log_phy[log_n] = int'(poll_phy);
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ctrl_en == 1, "R1 ctrl_en in reset", ctrl_en, 1);
    chk(acc_grant == 0 && acc_fail == 0, "R1 grant/fail in reset", {acc_grant, acc_fail}, 0);
    chk(poll_state == 2'b11, "R1 R2 state in reset", poll_state, 3);
    rst_n = 1;
  endtask

  task automatic t_round_robin();
    int n = 0;
    while (log_n < 7 && n < 200) begin @(negedge clk); n++; end
    chk(log_phy[0] == 0, "R1 first poll PHY", log_phy[0], 0);
    for (int i = 1; i < 7; i++)
      chk(log_phy[i] == i % NP, "R3 round-robin order", log_phy[i], i % NP);
    chk(poll_state == 2'b11, "R2 state while polling", poll_state, 3);
  endtask

  task automatic t_grant();
    int n = 0;
    bit bad = 0;
    acc_req = 1;
    @(negedge clk);
    chk(ctrl_en == 0, "R4 enable cleared next cycle", ctrl_en, 0);
    while (!acc_grant && n < 50) begin
      @(negedge clk); n++;
      if (acc_grant && poll_state != 2'b00) bad = 1;
    end
    chk(acc_grant == 1, "R4 grant given", acc_grant, 1);
    chk(!bad && poll_state == 2'b00, "R4 R2 stopped at grant", poll_state, 0);
  endtask

  task automatic t_long_access();
    bit bad = 0;
    for (int i = 0; i < 3 * QC; i++) begin
      @(negedge clk);
      if (!acc_grant || ctrl_en || poll_req) bad = 1;
    end
    chk(!bad, "R5 no polling during long access", bad, 0);
  endtask

  task automatic measure_quiet(input string tag);
    int n = 0;
    acc_req = 0;
    @(negedge clk);
    while (!ctrl_en && n < 10 * QC) begin
      n++; @(negedge clk);
    end
    chk(n == QC, tag, n, QC);
    chk(poll_state == 2'b11, "R6 R2 polling resumed", poll_state, 3);
  endtask

  task automatic t_cancel();
    bit bad = 0;
    int start;
    acc_req = 0;
    repeat (5) @(negedge clk);
    chk(ctrl_en == 0, "R7 still quiet", ctrl_en, 0);
    acc_req = 1;
    @(negedge clk);
    chk(acc_grant == 1, "R7 grant next cycle", acc_grant, 1);
    chk(ctrl_en == 0 && poll_state == 2'b00, "R7 no re-handshake", ctrl_en, 0);
    repeat (QC) begin
      @(negedge clk);
      if (ctrl_en) bad = 1;
    end
    chk(!bad, "R7 pending restart cancelled", bad, 0);
    start = log_n;
    measure_quiet("R7 R6 quiet window restarted");
    repeat (2 * LAT + 4) @(negedge clk);
    chk(log_n > start, "R6 polls issued again", log_n - start, 1);
  endtask

  task automatic t_timeout();
    int n = 0;
    int g = 0;
    ack_on = 0;
    while (resp_cnt != 1 && n < 100) begin @(negedge clk); n++; end
    acc_req = 1;
    n = 0;
    @(negedge clk);
    while (!acc_fail && n < 10 * TC) begin
      n++;
      if (acc_grant) g++;
      @(negedge clk);
    end
    chk(n == TC, "R8 timeout cycle", n, TC);
    chk(g == 0 && acc_grant == 0, "R8 no grant on timeout", g, 0);
    chk(ctrl_en == 1, "R8 enable restored", ctrl_en, 1);
    repeat (5) @(negedge clk);
    chk(acc_fail == 1, "R8 fail held while requested", acc_fail, 1);
    acc_req = 0;
    @(negedge clk);
    chk(acc_fail == 0, "R8 fail cleared after release", acc_fail, 0);
    n = log_n;
    ack_on = 1;
    repeat (3 * LAT + 4) @(negedge clk);
    chk(log_n > n, "R8 R3 polling continues", log_n - n, 1);
  endtask

  initial begin
    t_reset();
    t_round_robin();
    t_grant();
    t_long_access();
    measure_quiet("R6 re-enable delay");
    t_grant();
    t_cancel();
    t_timeout();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(20 * 100000);
    failed++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule